// File: doc/BRIEF.md
# TPM Register Fast-Path Responder

This block sits behind the TPM chip select of a SPI target. The serial framing logic in front of it decodes each TPM transaction into a direction, a 24-bit address and a byte count. The responder then decides how the transaction is handled. It either answers the read itself, with values that firmware has preloaded for a fixed set of standard TPM registers, or it hands the command to software by latching it.

The hardware answer covers eight registers:

- the per-locality access byte,
- status,
- interface capability,
- interrupt enable,
- interrupt vector,
- interrupt status,
- the vendor/device identifier word,
- the revision byte.

Several gates stand in front of that answer. The first is a check on the address prefix. The second is a check that the locality is in range. The third is the interface mode (CRB mode turns the fast path off). The fourth is a force-upload switch for the identity-type registers. A transaction in the TPM region whose locality is out of range can be answered with all-ones and silently dropped, or uploaded, depending on configuration. Three status flags are kept for software: a captured command is waiting, the write FIFO belongs to software, and the last uploaded read was cut short.

Top module: `tpm_hw_responder`

## Requirements
- R1: An accepted hardware-answered read streams `cmd_len` bytes (1 to 7) on `rd_data`, with `rd_valid` high for exactly that many cycles, starting in the cycle after acceptance. Bytes come from the selected 32-bit register value, least-significant byte first, beginning at the byte index given by address bits [1:0]. Bytes past the top of the 32-bit word read 0x00. Narrow registers (access, interrupt vector, revision) are zero-extended.
- R2: Register offsets are taken from address bits [11:0], and each location listed here is answered by hardware:
  - 0x000: access byte
  - 0x008: interrupt enable
  - 0x00C: interrupt vector
  - 0x010: interrupt status
  - 0x014: interface capability
  - 0x018: status
  - 0xF00: vendor ID in bits [15:0] and device ID in bits [31:16]
  - 0xF04: revision
- R3: A transaction is in the TPM region when address bits [23:16] equal 0xD4, or when `cfg_skip_prefix` is 1. With the prefix check active, any transaction outside the TPM region is uploaded.
- R4: Locality is address bits [15:12]. It is valid when below `NUM_LOC` (5 or 1). The access register read returns the byte of `val_access` that belongs to that locality, at bits [8*loc+7:8*loc].
- R5: With `cfg_skip_loc` = 1, a TPM-region transaction with an invalid locality is not uploaded. If it is a read, it returns 0xFF for every byte. If it is a write, it is discarded with no capture and no change to any flag.
- R6: With `cfg_skip_loc` = 0, a TPM-region transaction with an invalid locality is uploaded.
- R7: When `cfg_crb_mode` is 1, no transaction is answered by hardware and every accepted transaction is uploaded.
- R8: When `cfg_force_upload` is 1, reads of the access, status, vendor/device and revision registers are uploaded. The interrupt and interface-capability registers are still answered by hardware.
- R9: Writes, reads of any other offset, and every other case not answered by hardware are uploaded. An upload sets `cap_valid` in the next cycle and latches the direction, address and length. `cap_ack` clears `cap_valid`. A new upload in the same cycle as `cap_ack` wins.
- R10: An uploaded write sets `wrfifo_sw`. `wrfifo_release` clears it.
- R11: When a transfer ends (`xfer_end`) after an uploaded read, `rdfifo_abort` becomes 1 if `xfer_bytes` is below the captured length, and 0 otherwise.
- R12: After reset, `rd_valid`, `cap_valid`, `wrfifo_sw` and `rdfifo_abort` are all 0.
- R13: A command presented while a read stream is in progress is ignored. It produces no extra bytes, no capture and no flag change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_crb_mode | input | 1 | CRB interface mode; disables the hardware answer |
| cfg_force_upload | input | 1 | Upload access/status/ID/revision reads |
| cfg_skip_prefix | input | 1 | Treat every address as TPM region |
| cfg_skip_loc | input | 1 | Answer invalid localities with 0xFF instead of uploading |
| val_access | input | 8*NUM_LOC | Access byte per locality |
| val_sts | input | 32 | Status register value |
| val_intf_cap | input | 32 | Interface capability value |
| val_int_en | input | 32 | Interrupt enable value |
| val_int_vec | input | 8 | Interrupt vector value |
| val_int_sts | input | 32 | Interrupt status value |
| val_vendor | input | 16 | Vendor ID |
| val_device | input | 16 | Device ID |
| val_rid | input | 8 | Revision ID |
| cmd_valid | input | 1 | Decoded command present |
| cmd_read | input | 1 | 1 = read, 0 = write |
| cmd_addr | input | 24 | Transaction address |
| cmd_len | input | LEN_W | Data byte count |
| xfer_end | input | 1 | Transfer finished (chip select released) |
| xfer_bytes | input | LEN_W | Bytes actually clocked in that transfer |
| cap_ack | input | 1 | Software consumed the captured command |
| wrfifo_release | input | 1 | Software returns the write FIFO |
| rd_valid | output | 1 | Read byte valid |
| rd_data | output | 8 | Read byte |
| cap_valid | output | 1 | Captured command waiting for software |
| cap_read | output | 1 | Captured direction |
| cap_addr | output | 24 | Captured address |
| cap_len | output | LEN_W | Captured length |
| wrfifo_sw | output | 1 | Write FIFO owned by software |
| rdfifo_abort | output | 1 | Last uploaded read ended early |

## Verification
The bound assertions watch, cycle by cycle, the routing rules that depend only on the current inputs:

- CRB mode always leads to an upload with no bytes streamed.
- A prefix miss is captured with its address.
- A read with an invalid locality, under the skip setting, returns 0xFF.
- Writes never stream bytes.
- Acknowledgement clears the capture flag.
- The capture stays untouched while a stream is in progress.

The byte values and their order are shown only by the bench's scenarios:

- least-significant-first order with a start offset;
- zero fill beyond the word;
- per-locality access selection;
- the force-upload split between register groups;
- the early-abort flag.

// File: rtl/tpm_hw_responder.sv
module tpm_hw_responder #(
  parameter int NUM_LOC = 5,
  parameter int LEN_W   = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_crb_mode,
  input  logic                 cfg_force_upload,
  input  logic                 cfg_skip_prefix,
  input  logic                 cfg_skip_loc,
  input  logic [8*NUM_LOC-1:0] val_access,
  input  logic [31:0]          val_sts,
  input  logic [31:0]          val_intf_cap,
  input  logic [31:0]          val_int_en,
  input  logic [7:0]           val_int_vec,
  input  logic [31:0]          val_int_sts,
  input  logic [15:0]          val_vendor,
  input  logic [15:0]          val_device,
  input  logic [7:0]           val_rid,
  input  logic                 cmd_valid,
  input  logic                 cmd_read,
  input  logic [23:0]          cmd_addr,
  input  logic [LEN_W-1:0]     cmd_len,
  input  logic                 xfer_end,
  input  logic [LEN_W-1:0]     xfer_bytes,
  input  logic                 cap_ack,
  input  logic                 wrfifo_release,
  output logic                 rd_valid,
  output logic [7:0]           rd_data,
  output logic                 cap_valid,
  output logic                 cap_read,
  output logic [23:0]          cap_addr,
  output logic [LEN_W-1:0]     cap_len,
  output logic                 wrfifo_sw,
  output logic                 rdfifo_abort
);
  localparam logic [7:0] REGION = 8'hD4;

  logic [LEN_W-1:0] cnt_q;
  logic [31:0]      sh_q;
  logic             ff_q;
  logic             pend_rd_q;

  logic [3:0]  loc;
  logic        in_region, loc_ok, accept;
  logic        hit, ident;
  logic [31:0] word;
  logic [7:0]  acc_byte;
  logic        hw_read, bad_loc_skip, upload;

  assign loc       = cmd_addr[15:12];
  assign in_region = cfg_skip_prefix || (cmd_addr[23:16] == REGION);
  assign loc_ok    = int'(loc) < NUM_LOC;
  assign accept    = cmd_valid && (cnt_q == '0);

  always_comb begin
    acc_byte = 8'h00;
    for (int i = 0; i < NUM_LOC; i++)
      if (loc == 4'(i)) acc_byte = val_access[i*8 +: 8];
  end

  always_comb begin
    hit   = 1'b1;
    ident = 1'b0;
    word  = 32'h0;
    case (cmd_addr[11:2])
      10'h000: begin word = {24'h0, acc_byte};    ident = 1'b1; end
      10'h002:       word = val_int_en;
      10'h003:       word = {24'h0, val_int_vec};
      10'h004:       word = val_int_sts;
      10'h005:       word = val_intf_cap;
      10'h006: begin word = val_sts;              ident = 1'b1; end
      10'h3C0: begin word = {val_device, val_vendor}; ident = 1'b1; end
      10'h3C1: begin word = {24'h0, val_rid};     ident = 1'b1; end
      default:       hit = 1'b0;
    endcase
  end

  assign bad_loc_skip = !cfg_crb_mode && in_region && !loc_ok && cfg_skip_loc;
  assign hw_read = !cfg_crb_mode && in_region && loc_ok && cmd_read && hit &&
                   !(cfg_force_upload && ident);
  assign upload  = !hw_read && !bad_loc_skip;

  assign rd_valid = cnt_q != '0;
  assign rd_data  = ff_q ? 8'hFF : sh_q[7:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sh_q  <= '0;
      ff_q  <= 1'b0;
    end else if (accept) begin
      cnt_q <= (hw_read || (bad_loc_skip && cmd_read)) ? cmd_len : '0;
      sh_q  <= word >> {cmd_addr[1:0], 3'b000};
      ff_q  <= bad_loc_skip;
    end else if (rd_valid) begin
      cnt_q <= cnt_q - 1'b1;
      sh_q  <= sh_q >> 8;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_valid    <= 1'b0;
      cap_read     <= 1'b0;
      cap_addr     <= '0;
      cap_len      <= '0;
      wrfifo_sw    <= 1'b0;
      rdfifo_abort <= 1'b0;
      pend_rd_q    <= 1'b0;
    end else begin
      if (cap_ack) cap_valid <= 1'b0;
      if (wrfifo_release) wrfifo_sw <= 1'b0;
      if (xfer_end) begin
        pend_rd_q <= 1'b0;
        if (pend_rd_q) rdfifo_abort <= xfer_bytes < cap_len;
      end
      if (accept && upload) begin
        cap_valid <= 1'b1;
        cap_read  <= cmd_read;
        cap_addr  <= cmd_addr;
        cap_len   <= cmd_len;
        pend_rd_q <= cmd_read;
        if (!cmd_read) wrfifo_sw <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/tpm_hw_responder_chk.sv
module tpm_hw_responder_chk #(
  parameter int NUM_LOC = 5,
  parameter int LEN_W   = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_crb_mode,
  input logic             cfg_skip_prefix,
  input logic             cfg_skip_loc,
  input logic             cmd_valid,
  input logic             cmd_read,
  input logic [23:0]      cmd_addr,
  input logic [LEN_W-1:0] cmd_len,
  input logic             cap_ack,
  input logic             rd_valid,
  input logic [7:0]       rd_data,
  input logic             cap_valid,
  input logic [23:0]      cap_addr
);
  logic take, region, badloc;
  assign take   = cmd_valid && !rd_valid;
  assign region = cfg_skip_prefix || (cmd_addr[23:16] == 8'hD4);
  assign badloc = int'(cmd_addr[15:12]) >= NUM_LOC;

  AST_CRB_UPLOADS: assert property (@(posedge clk) disable iff (!rst_n)
    take && cfg_crb_mode |=> !rd_valid && cap_valid);  // R7

  AST_PREFIX_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    take && !cfg_crb_mode && !region |=> cap_valid && cap_addr == $past(cmd_addr));  // R3

  AST_BADLOC_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    take && !cfg_crb_mode && region && badloc && cfg_skip_loc && cmd_read && cmd_len != '0
    |=> rd_valid && rd_data == 8'hFF);  // R5

  AST_WRITE_NO_BYTES: assert property (@(posedge clk) disable iff (!rst_n)
    take && !cmd_read |=> !rd_valid);  // R9

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    cap_ack && !cmd_valid |=> !cap_valid);  // R9

  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && cmd_valid |=> $stable(cap_addr));  // R13
endmodule

bind tpm_hw_responder tpm_hw_responder_chk #(.NUM_LOC(NUM_LOC), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_crb_mode(cfg_crb_mode),
  .cfg_skip_prefix(cfg_skip_prefix), .cfg_skip_loc(cfg_skip_loc),
  .cmd_valid(cmd_valid), .cmd_read(cmd_read), .cmd_addr(cmd_addr),
  .cmd_len(cmd_len), .cap_ack(cap_ack), .rd_valid(rd_valid),
  .rd_data(rd_data), .cap_valid(cap_valid), .cap_addr(cap_addr)
);

// File: tb/tpm_hw_responder_test.sv
module tpm_hw_responder_test;
  localparam int NL = 5;
  localparam int LW = 3;

  logic clk = 0, rst_n = 0;
  logic cfg_crb_mode = 0, cfg_force_upload = 0, cfg_skip_prefix = 0, cfg_skip_loc = 0;
  logic [8*NL-1:0] val_access = {8'hA4, 8'hA3, 8'hA2, 8'hA1, 8'hA0};
  logic [31:0] val_sts = 32'h1122_3344, val_intf_cap = 32'h5566_7788;
  logic [31:0] val_int_en = 32'h99AA_BBCC, val_int_sts = 32'hDEAD_BEEF;
  logic [7:0]  val_int_vec = 8'h0D, val_rid = 8'h5A;
  logic [15:0] val_vendor = 16'h1234, val_device = 16'hABCD;
  logic cmd_valid = 0, cmd_read = 0;
  logic [23:0] cmd_addr = 0;
  logic [LW-1:0] cmd_len = 0, xfer_bytes = 0;
  logic xfer_end = 0, cap_ack = 0, wrfifo_release = 0;
  logic rd_valid, cap_valid, cap_read, wrfifo_sw, rdfifo_abort;
  logic [7:0] rd_data;
  logic [23:0] cap_addr;
  logic [LW-1:0] cap_len;

  int vectors = 0, miscompares = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;

  tpm_hw_responder #(.NUM_LOC(NL), .LEN_W(LW)) uut (.*);

  task automatic fail(string req, string what, int act, int exp);
    miscompares++;
    $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
  endtask

  task automatic check(string req, string what, int act, int exp);
    vectors++;
    if (act != exp) fail(req, what, act, exp);
  endtask

  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      vectors++;
      if (exp_q.size() == 0) fail("R1", "unexpected byte", rd_data, 0);
      else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (rd_data !== e) fail(t, "byte", rd_data, e);
      end
    end
  end

  task automatic expect_word(logic [31:0] w, int off, int len, string req);
    for (int k = 0; k < len; k++) begin
      exp_q.push_back((off + k) < 4 ? w[8*(off+k) +: 8] : 8'h00);
      tag_q.push_back(req);
    end
  endtask

  task automatic expect_ff(int len, string req);
    for (int k = 0; k < len; k++) begin exp_q.push_back(8'hFF); tag_q.push_back(req); end
  endtask

  task automatic issue(logic rd, logic [23:0] a, int len);
    @(negedge clk);
    cmd_valid = 1; cmd_read = rd; cmd_addr = a; cmd_len = LW'(len);
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic drain(int len);
    repeat (len + 1) @(negedge clk);
  endtask

  task automatic pulse_ack;
    cap_ack = 1; @(negedge clk); cap_ack = 0;
  endtask

  task automatic expect_upload(string req, logic [23:0] a, logic rd, int len);
    check(req, "cap_valid", cap_valid, 1);
    check(req, "cap_addr", cap_addr, a);
    check(req, "cap_read", cap_read, rd);
    check(req, "cap_len", cap_len, len);
    check(req, "no stream", rd_valid, 0);
    pulse_ack();
    check(req, "cap cleared", cap_valid, 0);
  endtask

  initial begin
    #500us;
    fail("WD", "watchdog", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R12", "rd_valid", rd_valid, 0);
    check("R12", "cap_valid", cap_valid, 0);
    check("R12", "wrfifo_sw", wrfifo_sw, 0);
    check("R12", "rdfifo_abort", rdfifo_abort, 0);
    rst_n = 1;

    // R1 R2 each hardware register
    expect_word(val_sts, 0, 4, "R1");       issue(1, 24'hD40018, 4); drain(4);
    expect_word(val_intf_cap, 0, 4, "R2");  issue(1, 24'hD40014, 4); drain(4);
    expect_word(val_int_en, 1, 2, "R1");    issue(1, 24'hD40009, 2); drain(2);
    expect_word(32'h0D, 0, 1, "R2");        issue(1, 24'hD4000C, 1); drain(1);
    expect_word(val_int_sts, 0, 4, "R2");   issue(1, 24'hD40010, 4); drain(4);
    expect_word({val_device, val_vendor}, 0, 4, "R2"); issue(1, 24'hD40F00, 4); drain(4);
    expect_word(32'h5A, 0, 1, "R2");        issue(1, 24'hD40F04, 1); drain(1);
    expect_word(val_sts, 2, 6, "R1");       issue(1, 24'hD4001A, 6); drain(6);
    check("R1", "hw read not captured", cap_valid, 0);

    // R4 locality selects access byte
    expect_word(32'hA3, 0, 2, "R4");        issue(1, 24'hD43000, 2); drain(2);
    expect_word(32'hA0, 0, 1, "R4");        issue(1, 24'hD40000, 1); drain(1);
    expect_word(32'hA4, 0, 1, "R4");        issue(1, 24'hD44000, 1); drain(1);

    // R3 prefix
    issue(1, 24'hC40018, 4); expect_upload("R3", 24'hC40018, 1, 4);
    cfg_skip_prefix = 1;
    expect_word(val_sts, 0, 4, "R3");       issue(1, 24'h000018, 4); drain(4);
    cfg_skip_prefix = 0;

    // R6 invalid locality uploaded
    issue(1, 24'hD45018, 1); expect_upload("R6", 24'hD45018, 1, 1);

    // R5 invalid locality answered with ones, writes discarded
    cfg_skip_loc = 1;
    expect_ff(3, "R5");                      issue(1, 24'hD47018, 3); drain(3);
    issue(0, 24'hD47018, 2); drain(2);
    check("R5", "write not captured", cap_valid, 0);
    check("R5", "write fifo untouched", wrfifo_sw, 0);
    cfg_skip_loc = 0;

    // R7 CRB
    cfg_crb_mode = 1;
    issue(1, 24'hD40018, 4); expect_upload("R7", 24'hD40018, 1, 4);
    cfg_crb_mode = 0;

    // R8 force upload split
    cfg_force_upload = 1;
    issue(1, 24'hD40018, 4); expect_upload("R8", 24'hD40018, 1, 4);
    issue(1, 24'hD40F04, 1); expect_upload("R8", 24'hD40F04, 1, 1);
    expect_word(val_int_en, 0, 4, "R8");    issue(1, 24'hD40008, 4); drain(4);
    cfg_force_upload = 0;

    // R9 R10 write upload, unknown offset
    issue(0, 24'hD40024, 2);
    check("R10", "wrfifo_sw set", wrfifo_sw, 1);
    expect_upload("R9", 24'hD40024, 0, 2);
    wrfifo_release = 1; @(negedge clk); wrfifo_release = 0;
    check("R10", "wrfifo_sw released", wrfifo_sw, 0);
    issue(1, 24'hD40030, 4); expect_upload("R9", 24'hD40030, 1, 4);

    // R11 abort flag
    issue(1, 24'h110000, 4);
    xfer_bytes = 2; xfer_end = 1; @(negedge clk); xfer_end = 0;
    check("R11", "abort set", rdfifo_abort, 1);
    pulse_ack();
    issue(1, 24'h110000, 2);
    xfer_bytes = 2; xfer_end = 1; @(negedge clk); xfer_end = 0;
    check("R11", "abort cleared", rdfifo_abort, 0);
    pulse_ack();

    // R13 command during stream ignored
    expect_word(val_sts, 0, 4, "R13");
    @(negedge clk);
    cmd_valid = 1; cmd_read = 1; cmd_addr = 24'hD40018; cmd_len = 4;
    @(negedge clk);
    cmd_addr = 24'hC40000; cmd_len = 2;
    @(negedge clk);
    cmd_valid = 0;
    drain(4);
    check("R13", "no capture while busy", cap_valid, 0);

    check("R1", "leftover expected bytes", exp_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule